// File: doc/BRIEF.md
# Converter Mute and Volume Sequencer

This block turns high-level mute and per-channel volume commands into an ordered series of register writes for an eight-channel output converter. It also drives the discrete, active-low mute line of the analog output stage. It sits above a serial register writer. For each write it presents a target code, a register address and a data byte, and it holds them until the writer answers with a done pulse.

Muting and unmuting run in opposite orders. A mute request first engages the converter's soft mute by register write. The block then waits a programmable settling delay and pulls the hardware mute line low. An unmute request releases the hardware line first, waits the same delay, and only then writes the register that releases soft mute. Volume requests name a channel 0 to 7 and give either a plain level (clamped into range) or an attenuation in half-decibel steps (range-checked). The eight channels land on a register set with a gap in it. Requests use a ready/valid handshake and are held off while a sequence is in progress. A request that cannot be honoured produces a one-cycle error pulse and no write.

Top module: `cvs_mute_vol_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters its idle state: `mute_n` = 0, `mute_state` = 1, `wr_valid` = 0, `err_pulse` = 0 and `req_ready` = 1.
- R2: `req_ready` is high only while no sequence is running. A request is taken at a rising edge where both `req_valid` and `req_ready` are high, and `req_ready` stays low from that edge until the sequence ends.
- R3: Request kind 1 (level) writes data `0x80 | L`. L is the signed `req_level`, forced to 0 when negative and to 0x7F when above 0x7F.
- R4: Request kind 2 (attenuation) takes `req_level` as signed half-dB steps in −127..0 and writes data `0x80 + (steps + 127)`.
- R5: Channel c in 0..5 is written to register address 0x04 + c, and channel 6 or 7 to address 0x0B + (c − 6).
- R6: A level or attenuation request with channel above 7, an attenuation outside −127..0, or request kind 3 is rejected. It causes no write, leaves `mute_n` and `mute_state` unchanged, and raises `err_pulse` for the one cycle after the accepting edge.
- R7: Kind 0 with `req_mute` = 1 first writes 0x03 to register 1. When `wr_done` is sampled at edge E, `mute_n` goes low at edge E + `settle_cycles` + 1, not before.
- R8: Kind 0 with `req_mute` = 0 drives `mute_n` high at the accepting edge A. It raises `wr_valid`, with register 1 and data 0x01, at edge A + `settle_cycles` + 1, not before.
- R9: A write presents `wr_target` = 1 and keeps `wr_valid`, `wr_addr` and `wr_data` stable until `wr_done` is sampled high. `wr_valid` drops at that edge.
- R10: `mute_state` changes only when a mute sequence completes. For muting it goes to 1 in the same edge that `mute_n` falls. For unmuting it goes to 0 in the edge that samples `wr_done` for the soft-mute release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| settle_cycles | input | 16 | Settling delay between soft-mute write and mute line change |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_kind | input | 2 | 0 mute control, 1 level, 2 attenuation, 3 reserved |
| req_mute | input | 1 | For kind 0: 1 mute, 0 unmute |
| req_chan | input | 4 | Channel index |
| req_level | input | 9 | Signed level or attenuation steps |
| wr_valid | output | 1 | Register write request to the serial writer |
| wr_target | output | 2 | Device code of the converter |
| wr_addr | output | 5 | Register address |
| wr_data | output | 8 | Register data |
| wr_done | input | 1 | Serial writer finished the current write |
| mute_n | output | 1 | Active-low hardware mute line |
| mute_state | output | 1 | Mute state as of the last completed sequence |
| err_pulse | output | 1 | One-cycle pulse on a rejected request |

## Verification
A volume request's write is visible one cycle after the accepting edge, as is the error pulse of a rejected one. The write clears one cycle after the edge that samples `wr_done`. A mute's line change lands exactly `settle_cycles` + 1 cycles after the soft-mute write is acknowledged. An unmute's release write appears `settle_cycles` + 1 cycles after acceptance. The bench drives and samples on falling edges and walks through those windows cycle by cycle. It checks that nothing moves early at every falling edge inside the window, and that the change is present at the first falling edge after it.

// File: rtl/cvs_pkg.sv
// Shared types and constants for the converter mute/volume sequencer.
// Assumes a single converter target and an 8-bit register data path.
package cvs_pkg;

    typedef enum logic [1:0] {
        CMD_MUTE  = 2'd0,
        CMD_LEVEL = 2'd1,
        CMD_ATTEN = 2'd2,
        CMD_RSVD  = 2'd3
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WR_VOL   = 3'd1,
        ST_WR_SM_ON = 3'd2,
        ST_WAIT_ON  = 3'd3,
        ST_WAIT_OFF = 3'd4,
        ST_WR_SM_OFF= 3'd5
    } seq_state_e;

    localparam int SOFTMUTE_REG  = 1;
    localparam int SOFTMUTE_ON   = 8'h03;
    localparam int SOFTMUTE_OFF  = 8'h01;

endpackage

// File: rtl/cvs_vol_encode.sv
// Volume request encoder: maps a channel onto its (gapped) register address,
// builds the register byte for a level or attenuation request, and flags
// requests that must be rejected. Purely combinational.
// Assumes DATA_W-1 level bits with the top data bit enabling attenuation.
module cvs_vol_encode
    import cvs_pkg::*;
#(
    parameter int CHAN_W   = 4,
    parameter int LVL_W    = 9,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 8,
    parameter int NUM_CHAN = 8,
    parameter int LO_SPLIT = 6,
    parameter int LO_BASE  = 4,
    parameter int HI_BASE  = 11
) (
    input  cmd_kind_e          kind,
    input  logic [CHAN_W-1:0]  chan,
    input  logic [LVL_W-1:0]   level,
    output logic [ADDR_W-1:0]  addr,
    output logic [DATA_W-1:0]  data,
    output logic               reject
);
    localparam int LVL_BITS = DATA_W - 1;
    localparam int FULL     = (1 << LVL_BITS) - 1;
    localparam logic signed [LVL_W-1:0] S_MAX  = LVL_W'(FULL);
    localparam logic signed [LVL_W-1:0] S_MIN  = -S_MAX;
    localparam logic signed [LVL_W-1:0] S_ZERO = '0;

    logic signed [LVL_W-1:0] lvl_s;
    logic signed [LVL_W-1:0] biased;
    logic [LVL_BITS-1:0]     code;
    logic                    chan_ok;
    logic                    att_ok;

    // Channel to register address, with the gap between the two groups.
    always_comb begin
        chan_ok = (32'(chan) < NUM_CHAN);
        if (32'(chan) < LO_SPLIT)
            addr = ADDR_W'(LO_BASE) + ADDR_W'(chan);
        else
            addr = ADDR_W'(HI_BASE) + ADDR_W'(chan) - ADDR_W'(LO_SPLIT);
    end

    // Level clamping or attenuation biasing into the register code.
    always_comb begin
        lvl_s  = $signed(level);
        biased = lvl_s + S_MAX;
        att_ok = (lvl_s >= S_MIN) && (lvl_s <= S_ZERO);
        code   = '0;
        if (kind == CMD_ATTEN)
            code = biased[LVL_BITS-1:0];
        else if (lvl_s < S_ZERO)
            code = '0;
        else if (lvl_s > S_MAX)
            code = LVL_BITS'(FULL);
        else
            code = lvl_s[LVL_BITS-1:0];
        data = {1'b1, code};
    end

    // Reject decision for volume-type requests.
    always_comb begin
        case (kind)
            CMD_LEVEL: reject = !chan_ok;
            CMD_ATTEN: reject = !chan_ok || !att_ok;
            default:   reject = 1'b1;
        endcase
    end
endmodule

// File: rtl/cvs_settle_timer.sv
// Settling delay counter. Loaded with the delay on entry to a wait state,
// counts down to zero and then reports expiry until reloaded.
// Assumes the load happens on the same edge the controller enters waiting.
module cvs_settle_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Expiry flag seen by the controller.
    always_comb expired = (cnt == '0);
endmodule

// File: rtl/cvs_seq_ctrl.sv
// Sequencing controller: accepts requests, issues register writes, runs the
// two opposite-order mute sequences and keeps the mute line and status bit.
// Assumes wr_done arrives only while wr_valid is high.
module cvs_seq_ctrl
    import cvs_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  cmd_kind_e         req_kind,
    input  logic              req_mute,
    input  logic [ADDR_W-1:0] enc_addr,
    input  logic [DATA_W-1:0] enc_data,
    input  logic              enc_reject,
    input  logic              wr_done,
    input  logic              settle_expired,
    output logic              settle_load,
    output logic              req_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              mute_n,
    output logic              mute_state,
    output logic              err_pulse
);
    seq_state_e state;
    logic       take;

    // Handshake and write strobe decode from the state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        take      = req_ready && req_valid;
        wr_valid  = (state == ST_WR_VOL) || (state == ST_WR_SM_ON) ||
                    (state == ST_WR_SM_OFF);
        settle_load = (state == ST_WR_SM_ON && wr_done) ||
                      (take && req_kind == CMD_MUTE && !req_mute);
    end

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            wr_addr    <= '0;
            wr_data    <= '0;
            mute_n     <= 1'b0;
            mute_state <= 1'b1;
            err_pulse  <= 1'b0;
        end else begin
            err_pulse <= 1'b0;
            case (state)
                ST_IDLE: if (take) begin
                    if (req_kind == CMD_MUTE) begin
                        if (req_mute) begin
                            wr_addr <= ADDR_W'(SOFTMUTE_REG);
                            wr_data <= DATA_W'(SOFTMUTE_ON);
                            state   <= ST_WR_SM_ON;
                        end else begin
                            mute_n  <= 1'b1;
                            state   <= ST_WAIT_OFF;
                        end
                    end else if (enc_reject) begin
                        err_pulse <= 1'b1;
                    end else begin
                        wr_addr <= enc_addr;
                        wr_data <= enc_data;
                        state   <= ST_WR_VOL;
                    end
                end
                ST_WR_VOL:   if (wr_done) state <= ST_IDLE;
                ST_WR_SM_ON: if (wr_done) state <= ST_WAIT_ON;
                ST_WAIT_ON: if (settle_expired) begin
                    mute_n     <= 1'b0;
                    mute_state <= 1'b1;
                    state      <= ST_IDLE;
                end
                ST_WAIT_OFF: if (settle_expired) begin
                    wr_addr <= ADDR_W'(SOFTMUTE_REG);
                    wr_data <= DATA_W'(SOFTMUTE_OFF);
                    state   <= ST_WR_SM_OFF;
                end
                ST_WR_SM_OFF: if (wr_done) begin
                    mute_state <= 1'b0;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cvs_mute_vol_seq.sv
// Top of the converter mute/volume sequencer. Wires the request encoder,
// the settling timer and the sequencing controller together.
// Assumes a serial register writer that acknowledges each write with wr_done.
module cvs_mute_vol_seq
    import cvs_pkg::*;
#(
    parameter int CHAN_W   = 4,
    parameter int LVL_W    = 9,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 8,
    parameter int TGT_W    = 2,
    parameter int TARGET   = 1,
    parameter int SETTLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_kind,
    input  logic                req_mute,
    input  logic [CHAN_W-1:0]   req_chan,
    input  logic [LVL_W-1:0]    req_level,
    output logic                wr_valid,
    output logic [TGT_W-1:0]    wr_target,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    input  logic                wr_done,
    output logic                mute_n,
    output logic                mute_state,
    output logic                err_pulse
);
    cmd_kind_e         kind;
    logic [ADDR_W-1:0] enc_addr;
    logic [DATA_W-1:0] enc_data;
    logic              enc_reject;
    logic              settle_load;
    logic              settle_expired;

    // Request kind cast and fixed target code.
    always_comb begin
        kind      = cmd_kind_e'(req_kind);
        wr_target = TGT_W'(TARGET);
    end

    cvs_vol_encode #(
        .CHAN_W(CHAN_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) enc_i (
        .kind(kind), .chan(req_chan), .level(req_level),
        .addr(enc_addr), .data(enc_data), .reject(enc_reject)
    );

    cvs_settle_timer #(.W(SETTLE_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load(settle_load),
        .load_val(settle_cycles), .expired(settle_expired)
    );

    cvs_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctl_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(kind),
        .req_mute(req_mute), .enc_addr(enc_addr), .enc_data(enc_data),
        .enc_reject(enc_reject), .wr_done(wr_done),
        .settle_expired(settle_expired), .settle_load(settle_load),
        .req_ready(req_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .mute_n(mute_n), .mute_state(mute_state),
        .err_pulse(err_pulse)
    );
endmodule

// File: rtl/cvs_mute_vol_seq_chk.sv
// Protocol checker for the sequencer, attached by bind.
module cvs_mute_vol_seq_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int TGT_W  = 2,
    parameter int TARGET = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              wr_valid,
    input logic [TGT_W-1:0]  wr_target,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_done,
    input logic              mute_n,
    input logic              mute_state,
    input logic              err_pulse
);
    a_r9_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_done) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    a_r9_target_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_target == TGT_W'(TARGET)));

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !req_ready);

    a_r6_err_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> ($past(req_valid && req_ready) && !wr_valid));

    a_r5_legal_addr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_addr == ADDR_W'(1)) ||
                      (wr_addr >= ADDR_W'(4) && wr_addr <= ADDR_W'(9)) ||
                      (wr_addr == ADDR_W'(11)) || (wr_addr == ADDR_W'(12))));

    a_r3_atten_enable_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr != ADDR_W'(1)) |-> wr_data[DATA_W-1]);

    a_r7_fall_with_state: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mute_n) |-> (mute_state && req_ready));

    a_r10_rise_before_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mute_n) |-> (mute_state && !req_ready));
endmodule

bind cvs_mute_vol_seq cvs_mute_vol_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TGT_W(TGT_W), .TARGET(TARGET)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .wr_valid(wr_valid), .wr_target(wr_target), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_done(wr_done), .mute_n(mute_n),
    .mute_state(mute_state), .err_pulse(err_pulse)
);

// File: tb/cvs_mute_vol_seq_tb_top.sv
module cvs_mute_vol_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] settle_cycles;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_kind;
    logic        req_mute;
    logic [3:0]  req_chan;
    logic [8:0]  req_level;
    logic        wr_valid;
    logic [1:0]  wr_target;
    logic [4:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        wr_done;
    logic        mute_n;
    logic        mute_state;
    logic        err_pulse;

    int total = 0;
    int bad   = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    cvs_mute_vol_seq dut_i (
        .clk(clk), .rst_n(rst_n), .settle_cycles(settle_cycles),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_mute(req_mute), .req_chan(req_chan), .req_level(req_level),
        .wr_valid(wr_valid), .wr_target(wr_target), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_done(wr_done), .mute_n(mute_n),
        .mute_state(mute_state), .err_pulse(err_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_addr(input int c);
        return (c < 6) ? 4 + c : 11 + (c - 6);
    endfunction

    function automatic bit exp_reject(input int kind, input int c, input int lvl);
        if (kind == 3 || c > 7) return 1;
        if (kind == 2 && (lvl < -127 || lvl > 0)) return 1;
        return 0;
    endfunction

    function automatic int exp_data(input int kind, input int lvl);
        int l;
        if (kind == 2) return 8'h80 + (lvl + 127);
        l = (lvl < 0) ? 0 : (lvl > 127 ? 127 : lvl);
        return 8'h80 | l;
    endfunction

    // Volume or reserved request, answered by the writer after lat cycles.
    task automatic vol_op(input int kind, input int c, input int lvl, input int lat);
        bit rej;
        int old_n, old_s;
        rej = exp_reject(kind, c, lvl);
        old_n = mute_n; old_s = mute_state;
        @(negedge clk);
        req_valid = 1; req_kind = 2'(kind); req_chan = 4'(c); req_level = 9'(lvl);
        @(negedge clk);
        req_valid = 0;
        chk(err_pulse == rej, "R6 err_pulse", err_pulse, rej);
        if (rej) begin
            chk(!wr_valid && req_ready, "R6 no write on reject", wr_valid, 0);
            chk(mute_n == old_n && mute_state == old_s, "R6 mute untouched",
                {mute_n, mute_state}, {old_n[0], old_s[0]});
        end else begin
            chk(wr_valid, "R9 wr_valid", wr_valid, 1);
            chk(wr_target == 2'd1, "R9 target", wr_target, 1);
            chk(wr_addr == exp_addr(c), "R5 address", wr_addr, exp_addr(c));
            chk(wr_data == exp_data(kind, lvl), kind == 2 ? "R4 atten data" : "R3 level data",
                wr_data, exp_data(kind, lvl));
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                chk(wr_valid && !req_ready, "R2 held while writing", req_ready, 0);
            end
            wr_done = 1;
            @(negedge clk);
            wr_done = 0;
            chk(!wr_valid && req_ready, "R9 write released", wr_valid, 0);
        end
    endtask

    task automatic mute_op(input int settle, input int lat);
        int old_n, old_s;
        old_n = mute_n; old_s = mute_state;
        settle_cycles = 16'(settle);
        @(negedge clk);
        req_valid = 1; req_kind = 2'd0; req_mute = 1;
        @(negedge clk);
        req_valid = 0;
        chk(wr_valid && wr_addr == 5'd1 && wr_data == 8'h03, "R7 soft mute write",
            {wr_addr, wr_data}, {5'd1, 8'h03});
        chk(mute_n == old_n, "R7 line waits for write", mute_n, old_n);
        for (int k = 0; k < lat; k++) @(negedge clk);
        wr_done = 1;
        @(negedge clk);
        wr_done = 0;
        chk(mute_n == old_n && mute_state == old_s && !req_ready, "R7 settle start",
            {mute_n, mute_state}, {old_n[0], old_s[0]});
        for (int k = 0; k < settle; k++) begin
            @(negedge clk);
            chk(mute_n == old_n && mute_state == old_s, "R10 no early change",
                {mute_n, mute_state}, {old_n[0], old_s[0]});
            chk(!req_ready, "R2 busy in settle", req_ready, 0);
        end
        @(negedge clk);
        chk(mute_n == 0, "R7 mute line low", mute_n, 0);
        chk(mute_state == 1 && req_ready, "R10 state muted", mute_state, 1);
    endtask

    task automatic unmute_op(input int settle, input int lat);
        int old_s;
        old_s = mute_state;
        settle_cycles = 16'(settle);
        @(negedge clk);
        req_valid = 1; req_kind = 2'd0; req_mute = 0;
        @(negedge clk);
        req_valid = 0;
        chk(mute_n == 1 && !wr_valid, "R8 line released first", mute_n, 1);
        chk(mute_state == old_s, "R10 state held", mute_state, old_s);
        for (int k = 0; k < settle; k++) begin
            @(negedge clk);
            chk(!wr_valid && !req_ready, "R8 no early write", wr_valid, 0);
        end
        @(negedge clk);
        chk(wr_valid && wr_addr == 5'd1 && wr_data == 8'h01, "R8 soft mute release",
            {wr_valid, wr_addr, wr_data}, {1'b1, 5'd1, 8'h01});
        chk(mute_state == old_s, "R10 state held in write", mute_state, old_s);
        for (int k = 0; k < lat; k++) @(negedge clk);
        wr_done = 1;
        @(negedge clk);
        wr_done = 0;
        chk(mute_state == 0 && !wr_valid && req_ready, "R10 state unmuted", mute_state, 0);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; req_valid = 0; req_kind = 0; req_mute = 0; req_chan = 0;
        req_level = 0; wr_done = 0; settle_cycles = 0;
        repeat (3) @(negedge clk);
        chk(mute_n == 0 && mute_state == 1, "R1 reset mute", {mute_n, mute_state}, 2'b01);
        chk(!wr_valid && !err_pulse && req_ready, "R1 reset idle",
            {wr_valid, err_pulse, req_ready}, 3'b001);
        rst_n = 1;
        @(negedge clk);

        unmute_op(3, 1);
        // Directed corners
        vol_op(1, 5, 64, 0);
        vol_op(1, 6, 10, 2);
        vol_op(1, 7, -1, 0);
        vol_op(1, 0, 128, 1);
        vol_op(1, 3, 255, 0);
        vol_op(1, 4, -256, 0);
        vol_op(1, 8, 5, 0);
        vol_op(1, 15, 5, 0);
        vol_op(2, 2, -127, 0);
        vol_op(2, 7, 0, 0);
        vol_op(2, 1, -128, 0);
        vol_op(2, 1, 1, 0);
        vol_op(3, 0, 0, 0);
        mute_op(0, 0);
        vol_op(3, 2, 0, 0);
        mute_op(2, 1);
        unmute_op(0, 0);
        // Random volume traffic
        for (int i = 0; i < 60; i++) begin
            int kind, c, lvl, lat;
            kind = 1 + int'($urandom_range(0, 2));
            c    = int'($urandom_range(0, 9));
            lvl  = int'($urandom_range(0, 511)) - 256;
            if (kind == 2 && $urandom_range(0, 3) != 0) lvl = -int'($urandom_range(0, 127));
            lat  = int'($urandom_range(0, 3));
            vol_op(kind, c, lvl, lat);
        end
        for (int i = 0; i < 4; i++) begin
            mute_op(int'($urandom_range(0, 9)), int'($urandom_range(0, 3)));
            unmute_op(int'($urandom_range(0, 9)), int'($urandom_range(0, 3)));
        end
        finish_run();
    end
endmodule